// File: doc/BRIEF.md
# UART Receive/Transmit Line Status Tracker

This block builds the 8-bit line status word for one UART channel running with FIFOs enabled. A receiver hands it each completed character together with three qualifiers (parity error, framing error, break). The block stores the byte in a 128-entry receive FIFO and keeps the three qualifiers beside it as an error tag. The CPU removes bytes with a pop strobe and reads the status word with a separate read strobe. On the transmit side the block only watches two occupancy levels supplied by the transmitter: transmit FIFO empty and shift register empty.

The per-character error bits always describe the byte at the head of the FIFO, not the byte that arrived last. An aggregate error bit stays up as long as any stored byte still carries a tag. It is maintained by a counter of tagged entries, so no scan of the storage is needed. When a character completes while the FIFO is full, that character is dropped and an overrun is flagged; the stored bytes are left untouched. A break held across several frames puts only one break character into the FIFO. The overrun and break flags are sticky until the CPU reads the status word.

Top module: `uart_line_status`

## Requirements
- R1: After reset the status word is 0x60: only bit 5 and bit 6 are 1.
- R2: Bit 0 is 1 exactly when the receive FIFO holds at least one byte.
- R3: Bit 2 is the parity tag and bit 3 is the framing tag of the byte at the FIFO head. Both follow the head on every pop and are 0 while the FIFO is empty.
- R4: Bit 7 is 1 while any stored byte carries a parity, framing or break tag. It returns to 0 in the cycle after the last tagged byte is popped.
- R5: A character that completes while the FIFO holds 128 bytes, with no pop in the same cycle, is discarded. Bit 1 becomes 1, and the stored bytes and their order are unchanged.
- R6: The first break frame of a break condition sets bit 4 and is stored with its break tag. Further break frames are dropped until a non-break character arrives, which ends the condition.
- R7: A status read clears bits 1 and 4 in the next cycle. If a new overrun or break arrives in the same cycle as the read, the flag stays set.
- R8: Bit 5 shows the transmit FIFO empty input, and bit 6 shows the AND of the transmit FIFO empty and shift register empty inputs, each one clock later.
- R9: Bytes leave the FIFO in arrival order, and the head byte is presented on rxHeadData. A pop while the FIFO is empty has no effect.
- R10: A character that completes while the FIFO is full, in the same cycle as a pop, is stored and does not set bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| rxValid | input | 1 | A received character completed this cycle |
| rxData | input | 8 | Received character |
| rxParityErr | input | 1 | Character has a parity error |
| rxFrameErr | input | 1 | Character has no valid stop bit |
| rxBreak | input | 1 | Character is a break frame |
| cpuPop | input | 1 | CPU takes the head byte |
| statusRead | input | 1 | CPU reads the status word |
| txFifoEmpty | input | 1 | Transmit FIFO is empty |
| txShiftEmpty | input | 1 | Transmit shift register is empty |
| rxHeadData | output | 8 | Byte at the receive FIFO head |
| lineStatus | output | 8 | Line status word |

## Verification
The hardest cases to reach are the ones that need a completely full FIFO: an overrun that must leave all 128 stored bytes intact, and a push and a pop in the same cycle at full occupancy. Directed stimulus fills the FIFO with a counting pattern and then produces both cases. A full drain afterwards confirms the arrival order. Constrained random phases that favour pushing, followed by phases that favour popping, reach full occupancy again while error tags, break runs and status reads arrive at random. This exercises the tagged-entry counter across many push and pop overlaps.

// File: rtl/lsr_pkg.sv
package lsr_pkg;

  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
  } err_tag_t;

  typedef struct packed {
    logic push;
    logic pop;
  } fifo_cmd_t;

endpackage

// File: rtl/lsr_datapath.sv
module lsr_datapath
  import lsr_pkg::*;
#(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifo_cmd_t         cmd,
  input  logic [DATA_W-1:0] wrData,
  input  err_tag_t          wrTag,
  output logic [DATA_W-1:0] headData,
  output err_tag_t          headTag,
  output logic              fifoEmpty,
  output logic              fifoFull,
  output logic              anyErr
);

  localparam int AW      = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW      = $clog2(DEPTH + 1);
  localparam int ENTRY_W = DATA_W + $bits(err_tag_t);

  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [AW-1:0]      wrPtr, rdPtr;
  logic [CW-1:0]      count;
  logic [CW-1:0]      errCount;
  logic               tagIn, tagOut;

  assign fifoEmpty = (count == '0);
  assign fifoFull  = (count == CW'(DEPTH));
  assign headData  = mem[rdPtr][ENTRY_W-1 -: DATA_W];
  assign headTag   = err_tag_t'(mem[rdPtr][$bits(err_tag_t)-1:0]);
  assign anyErr    = (errCount != '0);
  assign tagIn     = |wrTag;
  assign tagOut    = |headTag;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (cmd.push) mem[wrPtr] <= {wrData, wrTag};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
      errCount <= '0;
    end else begin
      if (cmd.push) wrPtr <= nextPtr(wrPtr);
      if (cmd.pop)  rdPtr <= nextPtr(rdPtr);
      case ({cmd.push, cmd.pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
      case ({cmd.push && tagIn, cmd.pop && tagOut})
        2'b10:   errCount <= errCount + CW'(1);
        2'b01:   errCount <= errCount - CW'(1);
        default: errCount <= errCount;
      endcase
    end
  end

  // R5: occupancy can never pass the configured depth
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));

  // R4: tagged entries are a subset of stored entries
  p_err_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    errCount <= count);

  // R2: a lone push grows occupancy by one
  p_push_grows_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.push && !cmd.pop) |=> count == $past(count) + CW'(1));

  // R9: no pop may reach an empty store
  p_pop_nonempty_r9: assert property (@(posedge clk) disable iff (!rstN)
    cmd.pop |-> count != '0);

endmodule

// File: rtl/lsr_ctrl.sv
module lsr_ctrl
  import lsr_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      rxValid,
  input  logic      rxBreak,
  input  logic      cpuPop,
  input  logic      statusRead,
  input  logic      txFifoEmpty,
  input  logic      txShiftEmpty,
  input  logic      fifoEmpty,
  input  logic      fifoFull,
  output fifo_cmd_t cmd,
  output logic      overrunFlag,
  output logic      breakFlag,
  output logic      txHoldEmpty,
  output logic      txAllEmpty
);

  logic breakHold;
  logic frameAccept;
  logic popOk;
  logic overrunSet;
  logic breakSet;

  assign popOk       = cpuPop && !fifoEmpty;
  assign frameAccept = rxValid && !(breakHold && rxBreak);
  assign overrunSet  = frameAccept && fifoFull && !popOk;
  assign breakSet    = frameAccept && rxBreak;

  always_comb begin
    cmd      = '0;
    cmd.pop  = popOk;
    cmd.push = frameAccept && (!fifoFull || popOk);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      breakHold   <= 1'b0;
      overrunFlag <= 1'b0;
      breakFlag   <= 1'b0;
      txHoldEmpty <= 1'b1;
      txAllEmpty  <= 1'b1;
    end else begin
      if (rxValid) breakHold <= rxBreak;
      overrunFlag <= overrunSet || (overrunFlag && !statusRead);
      breakFlag   <= breakSet   || (breakFlag   && !statusRead);
      txHoldEmpty <= txFifoEmpty;
      txAllEmpty  <= txFifoEmpty && txShiftEmpty;
    end
  end

  // R5: the store is never written while full unless a slot frees up
  p_full_guard_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.push && fifoFull) |-> cmd.pop);

  // R6: repeated break frames never reach the store
  p_brk_once_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxBreak && breakHold) |-> !cmd.push);

  // R7: a read with nothing new clears the sticky overrun flag
  p_rdclr_r7: assert property (@(posedge clk) disable iff (!rstN)
    (statusRead && !(rxValid && fifoFull && !cpuPop)) |=> !overrunFlag);

  // R8: holding-empty tracks the transmit FIFO input one cycle late
  p_thre_r8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> txHoldEmpty == $past(txFifoEmpty));

endmodule

// File: rtl/uart_line_status.sv
module uart_line_status
  import lsr_pkg::*;
#(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  input  logic              rxParityErr,
  input  logic              rxFrameErr,
  input  logic              rxBreak,
  input  logic              cpuPop,
  input  logic              statusRead,
  input  logic              txFifoEmpty,
  input  logic              txShiftEmpty,
  output logic [DATA_W-1:0] rxHeadData,
  output logic [7:0]        lineStatus
);

  fifo_cmd_t cmd;
  err_tag_t  wrTag, headTag;
  logic      fifoEmpty, fifoFull, anyErr;
  logic      overrunFlag, breakFlag, txHoldEmpty, txAllEmpty;

  assign wrTag = '{brk: rxBreak, frm: rxFrameErr, par: rxParityErr};

  lsr_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .rxValid     (rxValid),
    .rxBreak     (rxBreak),
    .cpuPop      (cpuPop),
    .statusRead  (statusRead),
    .txFifoEmpty (txFifoEmpty),
    .txShiftEmpty(txShiftEmpty),
    .fifoEmpty   (fifoEmpty),
    .fifoFull    (fifoFull),
    .cmd         (cmd),
    .overrunFlag (overrunFlag),
    .breakFlag   (breakFlag),
    .txHoldEmpty (txHoldEmpty),
    .txAllEmpty  (txAllEmpty)
  );

  lsr_datapath #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .wrData   (rxData),
    .wrTag    (wrTag),
    .headData (rxHeadData),
    .headTag  (headTag),
    .fifoEmpty(fifoEmpty),
    .fifoFull (fifoFull),
    .anyErr   (anyErr)
  );

  always_comb begin
    lineStatus    = '0;
    lineStatus[7] = anyErr;
    lineStatus[6] = txAllEmpty;
    lineStatus[5] = txHoldEmpty;
    lineStatus[4] = breakFlag;
    lineStatus[3] = headTag.frm && !fifoEmpty;
    lineStatus[2] = headTag.par && !fifoEmpty;
    lineStatus[1] = overrunFlag;
    lineStatus[0] = !fifoEmpty;
  end

  // R3: head error bits stay quiet while nothing is stored
  p_head_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    !lineStatus[0] |-> lineStatus[3:2] == 2'b00 && !lineStatus[7]);

endmodule

// File: tb/sim_uart_line_status.sv
`timescale 1ns/1ps
module sim_uart_line_status;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic       rxValid = 0, rxParityErr = 0, rxFrameErr = 0, rxBreak = 0;
  logic [7:0] rxData = 0;
  logic       cpuPop = 0, statusRead = 0;
  logic       txFifoEmpty = 1, txShiftEmpty = 1;
  logic [7:0] rxHeadData, lineStatus;

  uart_line_status u0 (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData),
    .rxParityErr(rxParityErr), .rxFrameErr(rxFrameErr), .rxBreak(rxBreak),
    .cpuPop(cpuPop), .statusRead(statusRead), .txFifoEmpty(txFifoEmpty),
    .txShiftEmpty(txShiftEmpty), .rxHeadData(rxHeadData), .lineStatus(lineStatus)
  );

  int checks = 0, failures = 0;
  bit finished = 0;

  logic [10:0] mq [128];
  int mh, mt, mc;
  bit mOvr, mBrk, mHold, mThr, mTemt;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    mh = 0; mt = 0; mc = 0;
    mOvr = 0; mBrk = 0; mHold = 0; mThr = 1; mTemt = 1;
  endtask

  task automatic modelStep();
    bit popOk, full, accept, pushOk, ovrSet, brkSet;
    popOk  = cpuPop && (mc != 0);
    full   = (mc == 128);
    accept = rxValid && !(mHold && rxBreak);
    pushOk = accept && (!full || popOk);
    ovrSet = accept && full && !popOk;
    brkSet = accept && rxBreak;
    if (rxValid) mHold = rxBreak;
    if (popOk) begin mh = (mh + 1) % 128; mc--; end
    if (pushOk) begin
      mq[mt] = {rxData, rxBreak, rxFrameErr, rxParityErr};
      mt = (mt + 1) % 128; mc++;
    end
    mOvr  = ovrSet || (mOvr && !statusRead);
    mBrk  = brkSet || (mBrk && !statusRead);
    mThr  = txFifoEmpty;
    mTemt = txFifoEmpty && txShiftEmpty;
  endtask

  function automatic bit modelAnyErr();
    for (int i = 0; i < mc; i++)
      if (mq[(mh + i) % 128][2:0] != 3'b000) return 1;
    return 0;
  endfunction

  task automatic compareAll();
    logic [10:0] h;
    h = mq[mh];
    chk("R2 data-ready", int'(lineStatus[0]), int'(mc != 0));
    chk("R3 head parity/framing", int'(lineStatus[3:2]),
        (mc != 0) ? int'({h[1], h[0]}) : 0);
    chk("R4 aggregate error", int'(lineStatus[7]), int'(modelAnyErr()));
    chk("R5 overrun", int'(lineStatus[1]), int'(mOvr));
    chk("R6 break flag", int'(lineStatus[4]), int'(mBrk));
    chk("R8 tx empty bits", int'(lineStatus[6:5]), int'({mTemt, mThr}));
    if (mc != 0) chk("R9 head data", int'(rxHeadData), int'(h[10:3]));
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    modelStep();
    compareAll();
  endtask

  task automatic drive(input bit v, input logic [7:0] d, input bit pe, input bit fe,
                       input bit bk, input bit pop, input bit srd);
    rxValid = v; rxData = d; rxParityErr = pe; rxFrameErr = fe; rxBreak = bk;
    cpuPop = pop; statusRead = srd;
  endtask

  task automatic idle();
    drive(0, 8'h00, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset status", int'(lineStatus), 32'h60);

    // Fill to full with a counting pattern
    for (int i = 0; i < 128; i++) begin
      drive(1, 8'(i), 0, 0, 0, 0, 0); tick();
    end
    // Overrun: dropped, contents intact
    drive(1, 8'hEE, 0, 0, 0, 0, 0); tick();
    chk("R5 overrun set when full", int'(lineStatus[1]), 1);
    chk("R5 head unchanged after overrun", int'(rxHeadData), 0);
    // Status read clears overrun
    drive(0, 8'h00, 0, 0, 0, 0, 1); tick();
    chk("R7 overrun cleared by read", int'(lineStatus[1]), 0);
    // Simultaneous push and pop at full
    drive(1, 8'hA5, 0, 0, 0, 1, 0); tick();
    chk("R10 no overrun on push+pop at full", int'(lineStatus[1]), 0);
    chk("R10 head advanced", int'(rxHeadData), 1);
    // Read clears while a new overrun arrives: set wins
    drive(1, 8'h77, 0, 0, 0, 0, 1); tick();
    chk("R7 set wins over read clear", int'(lineStatus[1]), 1);
    // Drain completely in order
    for (int i = 0; i < 128; i++) begin
      drive(0, 8'h00, 0, 0, 0, 1, 1); tick();
    end
    chk("R9 empty after drain", int'(lineStatus[0]), 0);
    drive(0, 8'h00, 0, 0, 0, 1, 0); tick();
    chk("R9 pop on empty ignored", int'(lineStatus[0]), 0);

    // Break held for three frames, then a normal character
    for (int i = 0; i < 3; i++) begin
      drive(1, 8'h00, 0, 1, 1, 0, 0); tick();
    end
    drive(1, 8'h3C, 0, 0, 0, 0, 0); tick();
    chk("R6 break flag set", int'(lineStatus[4]), 1);
    chk("R6 framing tag at head", int'(lineStatus[3]), 1);
    drive(0, 8'h00, 0, 0, 0, 1, 1); tick();
    chk("R6 single break stored", int'(rxHeadData), 32'h3C);
    chk("R7 break cleared by read", int'(lineStatus[4]), 0);
    drive(0, 8'h00, 0, 0, 0, 1, 0); tick();

    // Aggregate error follows the tagged entry through the FIFO
    drive(1, 8'h11, 0, 0, 0, 0, 0); tick();
    drive(1, 8'h22, 1, 0, 0, 0, 0); tick();
    drive(1, 8'h33, 0, 0, 0, 0, 0); tick();
    chk("R4 aggregate set, tag not at head", int'(lineStatus[7]), 1);
    chk("R3 head parity clear", int'(lineStatus[2]), 0);
    drive(0, 8'h00, 0, 0, 0, 1, 0); tick();
    chk("R3 head parity after pop", int'(lineStatus[2]), 1);
    drive(0, 8'h00, 0, 0, 0, 1, 0); tick();
    chk("R4 aggregate clears after tagged pop", int'(lineStatus[7]), 0);

    // Transmit occupancy
    idle(); txFifoEmpty = 0; txShiftEmpty = 1; tick();
    chk("R8 holding not empty", int'(lineStatus[6:5]), 0);
    txFifoEmpty = 1; txShiftEmpty = 0; tick();
    chk("R8 shift busy", int'(lineStatus[6:5]), 1);

    // Random phases
    for (int c = 0; c < 6000; c++) begin
      bit pushBias;
      pushBias = ((c / 700) % 2) == 0;
      rxValid     = pushBias ? ($urandom % 10 < 8) : ($urandom % 10 < 3);
      rxData      = 8'($urandom);
      rxParityErr = ($urandom % 8 == 0);
      rxFrameErr  = ($urandom % 8 == 0);
      rxBreak     = mHold ? ($urandom % 3 != 0) : ($urandom % 16 == 0);
      cpuPop      = pushBias ? ($urandom % 10 < 1) : ($urandom % 10 < 7);
      statusRead  = ($urandom % 5 == 0);
      if ($urandom % 8 == 0) txFifoEmpty  = ~txFifoEmpty;
      if ($urandom % 8 == 0) txShiftEmpty = ~txShiftEmpty;
      tick();
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule